// File: doc/BRIEF.md
# Beacon-Referenced Reply Slot Timer

This block grants a slave node on a shared half-duplex bus the right to drive the bus. It does not wait for the end of the master's transmission. A free-running counter advances on every strobe of a periodic tick, nominally one millisecond. When the receive path reports the start-of-header character of a master message, the block captures the counter. From that captured value it measures the elapsed ticks, wrapping correctly when the counter rolls over.

The node's reply window starts a programmed number of ticks after the capture, plus one extra guard tick. The capture can fall anywhere between two ticks, and the guard tick covers that uncertainty. The window lasts a programmed number of ticks. For the whole window the block holds a transmit-permit output high, and this output can drive the line driver enable directly, whatever the reply length.

A warning output rises a programmable number of ticks before the window ends. The transmitter uses it to avoid starting a character that would run past the slot. Several nodes can share one master message by being given consecutive offsets.

Top module: `slot_beacon_timer`

## Requirements
- R1: The tick counter `tick_count_o` increments by exactly one on each cycle in which `tick_i` is high, holds otherwise, and wraps from 2^CNT_W-1 to 0.
- R2: After reset, `tx_permit_o` and `slot_warn_o` are low and the tick counter is zero.
- R3: A start-of-header pulse accepted while idle captures the counter. `tx_permit_o` stays low until the elapsed tick count since the capture reaches offset+1, and rises on the second clock edge after the tick that makes it so.
- R4: `tx_permit_o` stays high for exactly `len` ticks. It falls once the elapsed count reaches offset+1+len.
- R5: When the counter has wrapped since the capture, the elapsed count is taken as now + (2^CNT_W - captured), so the window timing is unaffected by the wrap.
- R6: A start-of-header pulse that arrives while the offset or the length input is zero schedules no window, and `tx_permit_o` stays low. The next valid pulse is accepted normally.
- R7: A start-of-header pulse that arrives while a window is pending or open is ignored. The captured time and the window already scheduled do not change.
- R8: Offset, length and warning count are latched at capture. Changing these inputs while a window is pending or open does not move or resize that window.
- R9: `slot_warn_o` is high exactly while `tx_permit_o` is high and the ticks remaining in the window are at most `warn_ticks_i` (as latched). It is never high outside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe of the periodic time base |
| soh_i | input | 1 | One-cycle pulse: master start-of-header detected |
| slot_ofs_i | input | OFS_W | Slot offset in ticks (0 is invalid) |
| slot_len_i | input | LEN_W | Slot length in ticks (0 is invalid) |
| warn_ticks_i | input | LEN_W | Remaining-tick threshold for the warning |
| tx_permit_o | output | 1 | Transmit and driver-enable permit for the slot |
| slot_warn_o | output | 1 | Slot is about to close |
| tick_count_o | output | CNT_W | Free-running tick counter |

## Verification
The bench builds the block with a 4-bit tick counter and 3-bit offset and length fields. With these sizes it can sweep every offset and length pair, including the invalid zeros. Every slot still fits inside one counter period, and the counter rolls over every sixteen ticks. The number of ticks issued before each capture varies, so many windows straddle the wrap. The bench injects stray start-of-header pulses and configuration changes in the middle of windows, so the ignore and latch rules are exercised at every slot size.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_OPEN = 2'd2
  } slot_state_e;

  // Ticks between a captured value and now on a counter of 'width' bits.
  function automatic logic [31:0] wrap_elapsed(input logic [31:0] now_v,
                                               input logic [31:0] then_v,
                                               input int unsigned width);
    logic [32:0] modulus;
    modulus = 33'd1 << width;
    if (now_v >= then_v) return now_v - then_v;
    return 32'({1'b0, now_v} + (modulus - {1'b0, then_v}));
  endfunction

  // First elapsed count at which the slot is open (one guard tick).
  function automatic logic [31:0] slot_first(input logic [31:0] ofs);
    return ofs + 32'd1;
  endfunction

  // Elapsed count at which the slot is closed again.
  function automatic logic [31:0] slot_last(input logic [31:0] ofs,
                                            input logic [31:0] len);
    return ofs + 32'd1 + len;
  endfunction

endpackage

// File: rtl/slot_tick_counter.sv
module slot_tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      count_o <= '0;
    else if (tick_i) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/slot_capture.sv
module slot_capture #(
  parameter int CNT_W = 16,
  parameter int OFS_W = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] warn_i,
  output logic [CNT_W-1:0] cap_o,
  output logic [OFS_W-1:0] ofs_o,
  output logic [LEN_W-1:0] len_o,
  output logic [LEN_W-1:0] warn_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_o  <= '0;
      ofs_o  <= '0;
      len_o  <= '0;
      warn_o <= '0;
    end else if (accept_i) begin
      cap_o  <= count_i;
      ofs_o  <= ofs_i;
      len_o  <= len_i;
      warn_o <= warn_i;
    end
  end
endmodule

// File: rtl/slot_window.sv
module slot_window
  import slot_sched_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soh_i,
  input  logic        cfg_ok_i,
  input  logic [31:0] elapsed_i,
  input  logic [31:0] first_i,
  input  logic [31:0] last_i,
  input  logic [31:0] warn_lim_i,
  output logic        accept_o,
  output logic        busy_o,
  output logic        permit_o,
  output logic        warn_o
);
  slot_state_e state_q, state_d;
  logic [31:0] remain_w;

  assign accept_o = soh_i && cfg_ok_i && (state_q == SLOT_IDLE);
  assign busy_o   = (state_q != SLOT_IDLE);
  assign remain_w = last_i - elapsed_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SLOT_IDLE: if (accept_o)              state_d = SLOT_WAIT;
      SLOT_WAIT: if (elapsed_i == first_i)  state_d = SLOT_OPEN;
      SLOT_OPEN: if (elapsed_i == last_i)   state_d = SLOT_IDLE;
      default:                              state_d = SLOT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SLOT_IDLE;
      permit_o <= 1'b0;
      warn_o   <= 1'b0;
    end else begin
      state_q  <= state_d;
      permit_o <= (state_d == SLOT_OPEN);
      warn_o   <= (state_d == SLOT_OPEN) && (remain_w <= warn_lim_i);
    end
  end
endmodule

// File: rtl/slot_beacon_timer.sv
module slot_beacon_timer
  import slot_sched_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int OFS_W = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             soh_i,
  input  logic [OFS_W-1:0] slot_ofs_i,
  input  logic [LEN_W-1:0] slot_len_i,
  input  logic [LEN_W-1:0] warn_ticks_i,
  output logic             tx_permit_o,
  output logic             slot_warn_o,
  output logic [CNT_W-1:0] tick_count_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cap_q;
  logic [OFS_W-1:0] ofs_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] wlim_q;
  logic             accept_w;
  logic             busy_w;
  logic             cfg_ok_w;
  logic [31:0]      elapsed_w;
  logic [31:0]      first_w;
  logic [31:0]      last_w;

  assign cfg_ok_w  = (|slot_ofs_i) && (|slot_len_i);
  assign elapsed_w = wrap_elapsed(32'(cnt_q), 32'(cap_q), CNT_W);
  assign first_w   = slot_first(32'(ofs_q));
  assign last_w    = slot_last(32'(ofs_q), 32'(len_q));
  assign tick_count_o = cnt_q;

  slot_tick_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .count_o(cnt_q)
  );

  slot_capture #(.CNT_W(CNT_W), .OFS_W(OFS_W), .LEN_W(LEN_W)) i_cap (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_w), .count_i(cnt_q),
    .ofs_i(slot_ofs_i), .len_i(slot_len_i), .warn_i(warn_ticks_i),
    .cap_o(cap_q), .ofs_o(ofs_q), .len_o(len_q), .warn_o(wlim_q)
  );

  slot_window i_win (
    .clk(clk), .rst_n(rst_n), .soh_i(soh_i), .cfg_ok_i(cfg_ok_w),
    .elapsed_i(elapsed_w), .first_i(first_w), .last_i(last_w),
    .warn_lim_i(32'(wlim_q)), .accept_o(accept_w), .busy_o(busy_w),
    .permit_o(tx_permit_o), .warn_o(slot_warn_o)
  );
endmodule

// File: rtl/slot_beacon_timer_chk.sv
module slot_beacon_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             soh_i,
  input logic             cfg_ok,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cap,
  input logic             busy,
  input logic [31:0]      elapsed,
  input logic [31:0]      first,
  input logic [31:0]      last,
  input logic             permit,
  input logic             warn
);
  // R1
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> count == CNT_W'($past(count) + 1'b1));
  // R1
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(count));
  // R3
  open_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(permit) |-> $past(elapsed) == $past(first));
  // R4
  close_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(permit) |-> $past(elapsed) == $past(last));
  // R6
  arm_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_ok));
  // R7
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && soh_i |=> $stable(cap));
  // R9
  warn_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warn |-> permit);
endmodule

bind slot_beacon_timer slot_beacon_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .soh_i(soh_i),
  .cfg_ok(cfg_ok_w), .count(cnt_q), .cap(cap_q), .busy(busy_w),
  .elapsed(elapsed_w), .first(first_w), .last(last_w),
  .permit(tx_permit_o), .warn(slot_warn_o)
);

// File: tb/test_slot_beacon_timer.sv
module test_slot_beacon_timer;
  localparam int CNT_W = 4;
  localparam int OFS_W = 3;
  localparam int LEN_W = 3;
  localparam int MODV  = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic soh = 1'b0;
  logic [OFS_W-1:0] ofs = '0;
  logic [LEN_W-1:0] len = '0;
  logic [LEN_W-1:0] wlim = '0;
  logic permit, warn;
  logic [CNT_W-1:0] count;

  int checks = 0;
  int errors = 0;
  int cnt_m = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  slot_beacon_timer #(.CNT_W(CNT_W), .OFS_W(OFS_W), .LEN_W(LEN_W)) i_slot_beacon_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .soh_i(soh),
    .slot_ofs_i(ofs), .slot_len_i(len), .warn_ticks_i(wlim),
    .tx_permit_o(permit), .slot_warn_o(warn), .tick_count_o(count)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Strobe for one cycle, then let two registers settle before sampling.
  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (2) @(negedge clk);
    cnt_m = (cnt_m + 1) % MODV;
  endtask

  task automatic do_soh();
    @(negedge clk) soh = 1'b1;
    @(negedge clk) soh = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2", "permit in reset", int'(permit), 0);
    chk("R2", "warn in reset", int'(warn), 0);
    chk("R2", "count in reset", int'(count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "permit after reset", int'(permit), 0);

    for (int o = 0; o < 8; o++) begin
      for (int l = 0; l < 8; l++) begin
        int pre;
        int cap_m;
        int wl;
        bit valid;
        ofs = OFS_W'(o);
        len = LEN_W'(l);
        wl = (o * 3 + l) % 8;
        wlim = LEN_W'(wl);
        pre = (o + l) % 5;
        for (int p = 0; p < pre; p++) begin
          do_tick();
          chk("R1", "tick count", int'(count), cnt_m);
        end
        cap_m = cnt_m;
        valid = (o != 0) && (l != 0);
        do_soh();
        chk("R3", "permit right after capture", int'(permit), 0);
        for (int k = 1; k <= o + l + 2; k++) begin
          bit exp_p;
          bit exp_w;
          if (valid && k == 2) begin
            // R7 R8: stray header and new settings mid-window
            ofs = OFS_W'(7 - o);
            len = LEN_W'(7 - l + 1);
            wlim = LEN_W'(7 - wl);
            do_soh();
          end
          do_tick();
          exp_p = valid && (k >= o + 1) && (k < o + 1 + l);
          exp_w = exp_p && ((o + 1 + l - k) <= wl);
          if (!valid)
            chk("R6", "permit with invalid setting", int'(permit), 0);
          else if (k >= 2)
            chk("R7", "permit after ignored header/new setting (R8)", int'(permit), int'(exp_p));
          else if (cap_m + k >= MODV)
            chk("R5", "permit across wrap", int'(permit), int'(exp_p));
          else if (k <= o)
            chk("R3", "permit before offset+1", int'(permit), int'(exp_p));
          else
            chk("R4", "permit in window", int'(permit), int'(exp_p));
          if (cap_m + k >= MODV && valid)
            chk("R5", "permit across wrap", int'(permit), int'(exp_p));
          chk("R9", "warn", int'(warn), int'(exp_w));
          chk("R1", "tick count", int'(count), cnt_m);
        end
        ofs = OFS_W'(o);
        len = LEN_W'(l);
        wlim = LEN_W'(wl);
        chk("R4", "permit after window", int'(permit), 0);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule